// File: doc/BRIEF.md
# Legacy Serial Port Presence Prober

This block is a small bus master that takes a census of legacy serial controllers. When started, it visits four fixed I/O address ranges in a set order. At each one it writes a test byte into the controller's scratch register, which sits at offset 7 from the base, and then reads that register back. A range where the byte returns unchanged is taken to hold a working UART. The block never looks at an identification register. It relies only on a register that stores whatever was written to it.

The bus is a simple synchronous I/O bus. It has an address, write data, read data, one read strobe, one write strobe and a ready return. Every transaction holds its strobe until ready arrives. A bounded wait stops an empty address range from stalling the census. When all four ranges have been visited, a one-cycle completion pulse is raised. The number of controllers found and a per-range presence mask stay on the outputs until the next start.

Top module: `uart_census`

## Requirements
- R1: While reset is asserted and after it is released, `probe_done`, `uart_count`, `uart_mask`, `io_rd` and `io_wr` are all 0.
- R2: A census visits the scratch registers in this order: 0x03FF, 0x02FF, 0x03EF, 0x02EF (bases 0x3F8, 0x2F8, 0x3E8, 0x2E8 plus 7). At each address a write comes first and, if that write completes, a read follows. No other bus transaction occurs.
- R3: Every write drives `io_wdata` = 0x55 with `io_wr` high.
- R4: Slot i (0..3 in probe order) counts as present only when its read returns 0x55. Then bit i of `uart_mask` is set and `uart_count` is incremented. Any other read value leaves both unchanged, and `uart_count` always equals the number of set mask bits.
- R5: At most one strobe is high at a time. A strobe and its address stay unchanged until the cycle in which `io_rdy` is seen high, and then drop in the next cycle. A strobe that sees ready in its n-th cycle is high for exactly n cycles.
- R6: A strobe that sees no ready for 16 cycles is withdrawn after its 16th cycle, and the slot counts as absent. When a write ends this way, no read is issued for that slot. Ready arriving in the 16th cycle still counts as success.
- R7: A `probe_start` accepted while idle clears `uart_mask` and `uart_count` by the next cycle.
- R8: A `probe_start` asserted while a census is running has no effect. The transaction sequence and the final results are the same as without it.
- R9: `probe_done` is high for exactly one cycle after the last slot has been handled. At that point the results are final, and they stay stable with the bus idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_start | input | 1 | Begin a census (ignored while one is running) |
| probe_done | output | 1 | One-cycle pulse when the census completes |
| uart_count | output | 3 | Number of controllers found |
| uart_mask | output | 4 | Bit i set when slot i answered correctly |
| io_addr | output | 16 | I/O address of the current transaction |
| io_wdata | output | 8 | Write data |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_rdata | input | 8 | Read data, sampled when ready is high during a read |
| io_rdy | input | 1 | Transaction ready from the addressed device |

## Verification
The census is run against several device populations:
- A full set of working controllers with no wait states shows the basic order and the full count.
- A mix of one silent range, one slow working controller, one controller that returns a corrupted byte and one that always returns 0xFF separates true read-back from a plain acknowledgement.
- A fully silent population checks that each timed-out write is cut off at 16 cycles and that its read is skipped.
- A final mix places a controller that answers in the 16th wait cycle next to a silent one, which fixes the timeout boundary.

Some runs add a restart before the census and a stray start during it. These runs show that results are cleared on a real start and left untouched by a stray one.

// File: rtl/census_pkg.sv
package census_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SLOTS   = 4;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int COUNT_W = $clog2(SLOTS + 1);

    typedef enum logic [2:0] {
        PRB_IDLE     = 3'd0,
        PRB_WR_ISSUE = 3'd1,
        PRB_WR_WAIT  = 3'd2,
        PRB_RD_ISSUE = 3'd3,
        PRB_RD_WAIT  = 3'd4,
        PRB_ADVANCE  = 3'd5
    } probe_state_e;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } io_req_t;

    typedef struct packed {
        logic              ok;
        logic [BYTE_W-1:0] data;
    } io_rsp_t;

    // Candidate base addresses in visiting order.
    function automatic logic [ADDR_W-1:0] slot_base(input logic [SLOT_W-1:0] idx);
        logic [ADDR_W-1:0] b;
        case (idx)
            2'd0:    b = 16'h03F8;
            2'd1:    b = 16'h02F8;
            2'd2:    b = 16'h03E8;
            default: b = 16'h02E8;
        endcase
        return b;
    endfunction

    function automatic logic [ADDR_W-1:0] scratch_addr(input logic [SLOT_W-1:0] idx,
                                                       input logic [ADDR_W-1:0] ofs);
        return slot_base(idx) + ofs;
    endfunction

endpackage

// File: rtl/census_bus_port.sv
module census_bus_port
    import census_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  io_req_t           req,
    output logic              rsp_valid,
    output io_rsp_t           rsp,
    output logic [ADDR_W-1:0] io_addr,
    output logic [BYTE_W-1:0] io_wdata,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [BYTE_W-1:0] io_rdata,
    input  logic              io_rdy
);

    localparam int WAIT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_CYC - 1);

    logic              rd_q, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic [WAIT_W-1:0] wait_q;
    logic              rsp_valid_q;
    io_rsp_t           rsp_q;
    logic              busy;

    assign busy = rd_q | wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q        <= 1'b0;
            wr_q        <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            wait_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    rd_q    <= ~req.is_write;
                    wr_q    <=  req.is_write;
                    addr_q  <= req.addr;
                    wdata_q <= req.data;
                    wait_q  <= '0;
                end
            end else if (io_rdy) begin
                rd_q        <= 1'b0;
                wr_q        <= 1'b0;
                rsp_valid_q <= 1'b1;
                rsp_q.ok    <= 1'b1;
                rsp_q.data  <= rd_q ? io_rdata : '0;
            end else if (wait_q == WAIT_LAST) begin
                rd_q        <= 1'b0;
                wr_q        <= 1'b0;
                rsp_valid_q <= 1'b1;
                rsp_q.ok    <= 1'b0;
                rsp_q.data  <= '0;
            end else begin
                wait_q <= wait_q + WAIT_W'(1);
            end
        end
    end

    assign io_rd     = rd_q;
    assign io_wr     = wr_q;
    assign io_addr   = addr_q;
    assign io_wdata  = wdata_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp       = rsp_q;

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_rd, io_wr}));

    // R5
    no_req_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !busy);

    // R5
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !io_rdy && wait_q != WAIT_LAST) |=>
            (busy && $stable(io_addr) && $stable(io_rd)));

    // R5
    drop_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && io_rdy) |=> (!io_rd && !io_wr && rsp_valid && rsp.ok));

    // R6
    timeout_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !io_rdy && wait_q == WAIT_LAST) |=>
            (!io_rd && !io_wr && rsp_valid && !rsp.ok));

endmodule

// File: rtl/census_sequencer.sv
module census_sequencer
    import census_pkg::*;
#(
    parameter logic [BYTE_W-1:0] TEST_BYTE   = 8'h55,
    parameter logic [ADDR_W-1:0] SCRATCH_OFS = 16'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              req_valid,
    output io_req_t           req,
    input  logic              rsp_valid,
    input  io_rsp_t           rsp,
    output logic              clear,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic              done
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    probe_state_e      state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              done_q, done_d;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        done_d  = 1'b0;
        unique case (state_q)
            PRB_IDLE: begin
                if (start) begin
                    state_d = PRB_WR_ISSUE;
                    slot_d  = '0;
                end
            end
            PRB_WR_ISSUE: state_d = PRB_WR_WAIT;
            PRB_WR_WAIT: begin
                if (rsp_valid) state_d = rsp.ok ? PRB_RD_ISSUE : PRB_ADVANCE;
            end
            PRB_RD_ISSUE: state_d = PRB_RD_WAIT;
            PRB_RD_WAIT: begin
                if (rsp_valid) state_d = PRB_ADVANCE;
            end
            PRB_ADVANCE: begin
                if (slot_q == SLOT_LAST) begin
                    state_d = PRB_IDLE;
                    done_d  = 1'b1;
                end else begin
                    slot_d  = slot_q + SLOT_W'(1);
                    state_d = PRB_WR_ISSUE;
                end
            end
            default: state_d = PRB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PRB_IDLE;
            slot_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            done_q  <= done_d;
        end
    end

    always_comb begin
        req_valid    = (state_q == PRB_WR_ISSUE) || (state_q == PRB_RD_ISSUE);
        req.is_write = (state_q == PRB_WR_ISSUE);
        req.addr     = scratch_addr(slot_q, SCRATCH_OFS);
        req.data     = TEST_BYTE;
    end

    assign clear    = (state_q == PRB_IDLE) && start;
    assign hit      = (state_q == PRB_RD_WAIT) && rsp_valid && rsp.ok && (rsp.data == TEST_BYTE);
    assign hit_slot = slot_q;
    assign done     = done_q;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    read_after_good_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PRB_WR_WAIT && rsp_valid && !rsp.ok) |=> (state_q == PRB_ADVANCE));

    // R8
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != PRB_IDLE && state_q != PRB_ADVANCE && start) |=>
            ($stable(slot_q) && state_q != PRB_IDLE));

endmodule

// File: rtl/census_tally.sv
module census_tally
    import census_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               hit,
    input  logic [SLOT_W-1:0]  hit_slot,
    output logic [SLOTS-1:0]   mask,
    output logic [COUNT_W-1:0] count
);

    logic [SLOTS-1:0]   mask_q;
    logic [COUNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask_q  <= '0;
            count_q <= '0;
        end else if (hit) begin
            mask_q[hit_slot] <= 1'b1;
            count_q          <= count_q + COUNT_W'(1);
        end
    end

    assign mask  = mask_q;
    assign count = count_q;

    // R4
    count_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
        32'(count) == $countones(mask));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0 && mask == '0));

    // R4
    hit_marks_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !clear) |=> (count == $past(count) + COUNT_W'(1)));

endmodule

// File: rtl/uart_census.sv
module uart_census
    import census_pkg::*;
#(
    parameter int                TIMEOUT_CYC = 16,
    parameter logic [BYTE_W-1:0] TEST_BYTE   = 8'h55,
    parameter logic [ADDR_W-1:0] SCRATCH_OFS = 16'd7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               probe_start,
    output logic               probe_done,
    output logic [COUNT_W-1:0] uart_count,
    output logic [SLOTS-1:0]   uart_mask,
    output logic [ADDR_W-1:0]  io_addr,
    output logic [BYTE_W-1:0]  io_wdata,
    output logic               io_rd,
    output logic               io_wr,
    input  logic [BYTE_W-1:0]  io_rdata,
    input  logic               io_rdy
);

    logic              req_valid;
    io_req_t           req;
    logic              rsp_valid;
    io_rsp_t           rsp;
    logic              clear;
    logic              hit;
    logic [SLOT_W-1:0] hit_slot;

    census_sequencer #(
        .TEST_BYTE   (TEST_BYTE),
        .SCRATCH_OFS (SCRATCH_OFS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (probe_start),
        .req_valid (req_valid),
        .req       (req),
        .rsp_valid (rsp_valid),
        .rsp       (rsp),
        .clear     (clear),
        .hit       (hit),
        .hit_slot  (hit_slot),
        .done      (probe_done)
    );

    census_bus_port #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .rsp_valid (rsp_valid),
        .rsp       (rsp),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_rdata  (io_rdata),
        .io_rdy    (io_rdy)
    );

    census_tally u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .hit      (hit),
        .hit_slot (hit_slot),
        .mask     (uart_mask),
        .count    (uart_count)
    );

    // R9
    results_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_rd && !io_wr && !req_valid && !probe_start && !rsp_valid) |=>
            $stable(uart_mask));

endmodule

// File: tb/uart_census_test.sv
module uart_census_test;

    localparam int MODE_GOOD    = 0;
    localparam int MODE_SILENT  = 1;
    localparam int MODE_CORRUPT = 2;
    localparam int MODE_STUCK   = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        probe_start;
    logic        probe_done;
    logic [2:0]  uart_count;
    logic [3:0]  uart_mask;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        io_rd, io_wr;
    logic [7:0]  io_rdata;
    logic        io_rdy;

    int checks = 0;
    int errors = 0;

    int          dev_mode [4];
    int          dev_lat  [4];
    logic [7:0]  dev_reg  [4];
    logic [16:0] expq [$];

    always #2.5 clk = ~clk;

    uart_census uut (
        .clk         (clk),
        .rst         (rst),
        .probe_start (probe_start),
        .probe_done  (probe_done),
        .uart_count  (uart_count),
        .uart_mask   (uart_mask),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_rdata    (io_rdata),
        .io_rdy      (io_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] slot_addr(input int s);
        case (s)
            0:       return 16'h03FF;
            1:       return 16'h02FF;
            2:       return 16'h03EF;
            default: return 16'h02EF;
        endcase
    endfunction

    function automatic int addr_slot(input logic [15:0] a);
        for (int s = 0; s < 4; s++) if (slot_addr(s) == a) return s;
        return -1;
    endfunction

    // Behavioural device population, driven away from the active edge.
    int resp_wait = 0;
    always @(negedge clk) begin
        int s;
        io_rdy   <= 1'b0;
        io_rdata <= 8'h00;
        if (io_rd || io_wr) begin
            s = addr_slot(io_addr);
            if (s >= 0 && dev_mode[s] != MODE_SILENT && resp_wait == dev_lat[s]) begin
                io_rdy <= 1'b1;
                if (io_wr) dev_reg[s] = io_wdata;
                else if (dev_mode[s] == MODE_STUCK) io_rdata <= 8'hFF;
                else if (dev_mode[s] == MODE_CORRUPT) io_rdata <= dev_reg[s] ^ 8'h80;
                else io_rdata <= dev_reg[s];
            end
            resp_wait++;
        end else begin
            resp_wait = 0;
        end
    end

    // Reference model of the bus sequence, compared on every clock.
    logic prev_stb  = 1'b0;
    logic prev_done = 1'b0;
    int   dur       = 0;
    int   cur_slot  = 0;
    always @(negedge clk) begin
        logic stb;
        logic [16:0] e;
        stb = io_rd | io_wr;
        if (!rst) begin
            if (io_rd && io_wr) chk(1'b0, "R5 both strobes high", 3, 1);
            if (stb && !prev_stb) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected transaction", int'(io_addr), 0);
                end else begin
                    e = expq.pop_front();
                    chk({io_wr, io_addr} == e, "R2 transaction order/kind", int'({io_wr, io_addr}), int'(e));
                    if (io_wr) chk(io_wdata == 8'h55, "R3 write data", int'(io_wdata), 8'h55);
                end
                cur_slot = addr_slot(io_addr);
                dur = 0;
            end
            if (stb && prev_stb && dur > 0) begin
                // address must not move during a transaction
                if (addr_slot(io_addr) != cur_slot) chk(1'b0, "R5 address held", int'(io_addr), int'(slot_addr(cur_slot)));
            end
            if (stb) dur++;
            if (!stb && prev_stb && cur_slot >= 0) begin
                if (dev_mode[cur_slot] == MODE_SILENT)
                    chk(dur == 16, "R6 timeout strobe length", dur, 16);
                else
                    chk(dur == dev_lat[cur_slot] + 1, "R5 strobe held until ready", dur, dev_lat[cur_slot] + 1);
            end
            if (probe_done && prev_done) chk(1'b0, "R9 done longer than one cycle", 2, 1);
        end
        prev_stb  = stb;
        prev_done = probe_done;
    end

    task automatic setup(input int m0, l0, m1, l1, m2, l2, m3, l3);
        dev_mode[0] = m0; dev_lat[0] = l0;
        dev_mode[1] = m1; dev_lat[1] = l1;
        dev_mode[2] = m2; dev_lat[2] = l2;
        dev_mode[3] = m3; dev_lat[3] = l3;
        for (int s = 0; s < 4; s++) dev_reg[s] = 8'h00;
    endtask

    task automatic run_census(input int stray_at, input string tag);
        logic [3:0] em;
        int ec;
        int t;
        em = '0; ec = 0;
        expq.delete();
        for (int s = 0; s < 4; s++) begin
            expq.push_back({1'b1, slot_addr(s)});
            if (dev_mode[s] != MODE_SILENT) expq.push_back({1'b0, slot_addr(s)});
            if (dev_mode[s] == MODE_GOOD) begin em[s] = 1'b1; ec++; end
        end
        @(negedge clk); probe_start = 1'b1;
        @(negedge clk); probe_start = 1'b0;
        // R7: results cleared right after an accepted start
        chk(uart_count == 3'd0 && uart_mask == 4'd0, "R7 clear on start",
            int'({uart_count, uart_mask}), 0);
        t = 0;
        while (!probe_done && t < 2000) begin
            @(negedge clk); t++;
            if (t == stray_at) probe_start = 1'b1;       // R8 stray start
            else probe_start = 1'b0;
        end
        probe_start = 1'b0;
        chk(probe_done == 1'b1, {"R9 done seen ", tag}, int'(probe_done), 1);
        chk(uart_mask == em, {"R4 presence mask ", tag}, int'(uart_mask), int'(em));
        chk(int'(uart_count) == ec, {"R4 device count ", tag}, int'(uart_count), ec);
        chk(expq.size() == 0, {"R2 all transactions issued ", tag}, expq.size(), 0);
        @(negedge clk);
        chk(probe_done == 1'b0, "R9 done one cycle", int'(probe_done), 0);
        repeat (10) @(negedge clk);
        chk(uart_mask == em && int'(uart_count) == ec, {"R9 results held ", tag},
            int'({uart_count, uart_mask}), int'({3'(ec), em}));
        chk(!io_rd && !io_wr, "R9 bus idle after done", int'({io_rd, io_wr}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        probe_start = 1'b0;
        setup(MODE_GOOD, 0, MODE_GOOD, 0, MODE_GOOD, 0, MODE_GOOD, 0);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!probe_done && uart_count == 0 && uart_mask == 0 && !io_rd && !io_wr,
            "R1 reset state", int'({probe_done, uart_count, uart_mask, io_rd, io_wr}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!probe_done && uart_count == 0 && uart_mask == 0 && !io_rd && !io_wr,
            "R1 idle after reset", int'({probe_done, uart_count, uart_mask, io_rd, io_wr}), 0);

        // All four present, no wait states
        run_census(0, "all present");

        // Mixed: silent, slow good, corrupted, stuck at FF (also R7 after full result)
        setup(MODE_SILENT, 0, MODE_GOOD, 3, MODE_CORRUPT, 1, MODE_STUCK, 2);
        run_census(0, "mixed");

        // None present; stray start mid-run (R8, R6)
        setup(MODE_SILENT, 0, MODE_SILENT, 0, MODE_SILENT, 0, MODE_SILENT, 0);
        run_census(20, "none present");

        // Timeout boundary: answer in the 16th wait cycle, stray start again
        setup(MODE_GOOD, 15, MODE_GOOD, 0, MODE_SILENT, 0, MODE_GOOD, 5);
        run_census(9, "boundary");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule